// File: doc/BRIEF.md
# Window Watchdog with Staged Escalation

This block supervises a host with a window watchdog driven by a 1 ms tick strobe. Each watchdog period has two windows. First comes a closed window, in which servicing is not allowed. Then comes an open window, in which servicing is expected. An 8-bit code sets the length of each window, on a piecewise scale with three ranges.

When the watchdog is enabled, it first waits a programmable number of whole periods before the first closed window begins. The host services the watchdog by writing a key. A key write that comes too early raises a sticky early-update flag. An open window that ends without a valid key raises a sticky expired flag and triggers an escalation action. The host clears both flags by reading the status.

A 2-bit mode sets the escalation steps. The steps run from an interrupt pulse, to a reset request, to a power-down request. The power-down request carries a 2-bit shutdown code. The surrounding system provides a sleep input and a bit that sets whether the watchdog keeps running in sleep.

Top module: `wdg_window_top`

## Requirements
- R1: A window code c sets the window length in ticks as follows. For c in 0x00..0x1F the length is c+1. For c in 0x20..0x3F it is 34+2*(c-0x20). For c in 0x40..0xFF it is 100+4*(c-0x40).
- R2: With `mode_i`=00 the watchdog is idle. `open_o` stays low, no escalation pulse appears and no flag is set.
- R3: The watchdog starts when it leaves the idle state, when it leaves sleep hold-off, or on a `mode_wr_i` strobe. In each case it counts (`dly_i`+1) full periods, each of closed length plus open length in ticks, before the first closed window.
- R4: While `sleep_i`=1 and `slp_en_i`=0, the watchdog is held idle. With `slp_en_i`=1 it keeps running in sleep.
- R5: Any key write during the closed window sets `early_o` on the next cycle.
- R6: If the open window reaches its last tick with no valid key write, `expired_o` is set. A new closed window then starts.
- R7: A `stat_rd_i` strobe clears `early_o` and `expired_o`. A new set in the same cycle wins over the clear.
- R8: A key write in the open window whose data equals the key parameter (default 0xA5) starts a new closed window at once. It also returns escalation to its first step. A key with any other value is ignored.
- R9: Each expiry fires exactly one action. Mode 01 fires interrupt, then reset, then power-down for every later expiry. Mode 10 fires reset, then power-down. Mode 11 fires power-down every time.
- R10: When `pd_req_o` pulses, `pd_mode_o` holds the `pdmd_i` value sampled at that expiry. It keeps that value until the next power-down.
- R11: `open_o` is high exactly during the open window.
- R12: `irq_o`, `rst_req_o` and `pd_req_o` are single-cycle pulses, one cycle after the expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 ms time-base strobe |
| mode_i | input | 2 | Enable and escalation mode |
| mode_wr_i | input | 1 | Strobe: mode was written, restarts the start delay |
| dly_i | input | 3 | Start delay, in periods minus one |
| slp_en_i | input | 1 | 1 = keep running during sleep |
| sleep_i | input | 1 | System is in sleep |
| close_code_i | input | 8 | Closed window length code |
| open_code_i | input | 8 | Open window length code |
| pdmd_i | input | 2 | Shutdown code for power-down escalation |
| key_wr_i | input | 1 | Key write strobe |
| key_i | input | 8 | Key write data |
| stat_rd_i | input | 1 | Status read strobe, clears flags |
| open_o | output | 1 | Open window active |
| early_o | output | 1 | Sticky early-update flag |
| expired_o | output | 1 | Sticky expired flag |
| irq_o | output | 1 | Interrupt escalation pulse |
| rst_req_o | output | 1 | Reset request pulse |
| pd_req_o | output | 1 | Power-down request pulse |
| pd_mode_o | output | 2 | Shutdown code of last power-down |

## Verification
Directed runs pick code pairs on each range boundary of the length scale, with different start delays. Measuring when `open_o` first rises and how long it stays high separates the three decode ranges and the delay count. Per-mode expiry runs show the order of escalation actions. A valid key and a wrong key, each placed inside the open window, show whether service resets the escalation step. Random runs mix uneven tick strobes, key writes with right and wrong data, status reads, sleep toggles and mode rewrites. A cycle model in the bench compares every output against these runs, so timing slips in the window counters show up as mismatches.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_DELAY  = 2'd1,
    PH_CLOSED = 2'd2,
    PH_OPEN   = 2'd3
  } wdg_phase_e;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_FULL = 2'b01;
  localparam logic [1:0] MODE_RST  = 2'b10;
  localparam logic [1:0] MODE_PD   = 2'b11;
endpackage

// File: rtl/wdg_len_dec.sv
module wdg_len_dec #(
  parameter int CODE_W = 8,
  parameter int LEN_W  = 10
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LEN_W-1:0]  len_o
);
  localparam int BRK1 = 32;
  localparam int BRK2 = 64;
  localparam int BASE2 = 34;
  localparam int BASE3 = 100;

  logic [LEN_W-1:0] c;

  always_comb begin
    c = LEN_W'(code_i);
    if (code_i < CODE_W'(BRK1))
      len_o = c + LEN_W'(1);
    else if (code_i < CODE_W'(BRK2))
      len_o = LEN_W'(BASE2) + ((c - LEN_W'(BRK1)) << 1);
    else
      len_o = LEN_W'(BASE3) + ((c - LEN_W'(BRK2)) << 2);
  end
endmodule

// File: rtl/wdg_phase_ctl.sv
module wdg_phase_ctl
  import wdg_pkg::*;
#(
  parameter int          LEN_W = 10,
  parameter int          DLY_W = 3,
  parameter int          KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic             mode_wr_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             slp_en_i,
  input  logic             sleep_i,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [LEN_W-1:0] close_len_i,
  input  logic [LEN_W-1:0] open_len_i,
  output wdg_phase_e       phase_o,
  output logic             active_o,
  output logic             restart_o,
  output logic             service_o,
  output logic             early_hit_o,
  output logic             expire_o
);
  localparam int PER_W = LEN_W + 1;

  wdg_phase_e       phase_q, phase_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] prd_q, prd_d;
  logic [PER_W-1:0] period, cl_last, op_last;
  logic             upd_en;

  always_comb begin
    period  = PER_W'(close_len_i) + PER_W'(open_len_i);
    cl_last = PER_W'(close_len_i) - PER_W'(1);
    op_last = PER_W'(open_len_i) - PER_W'(1);

    active_o    = (mode_i != MODE_OFF) && !(sleep_i && !slp_en_i);
    restart_o   = active_o && ((phase_q == PH_OFF) || mode_wr_i);
    service_o   = active_o && !restart_o && (phase_q == PH_OPEN)
                  && key_wr_i && (key_i == KEY);
    early_hit_o = active_o && !restart_o && (phase_q == PH_CLOSED) && key_wr_i;
    expire_o    = active_o && !restart_o && (phase_q == PH_OPEN) && !service_o
                  && tick_i && (cnt_q == op_last);

    phase_d = phase_q;
    cnt_d   = cnt_q;
    prd_d   = prd_q;
    if (!active_o) begin
      phase_d = PH_OFF;
      cnt_d   = '0;
      prd_d   = '0;
    end else if (restart_o) begin
      phase_d = PH_DELAY;
      cnt_d   = '0;
      prd_d   = '0;
    end else begin
      unique case (phase_q)
        PH_DELAY: if (tick_i) begin
          if (cnt_q == period - PER_W'(1)) begin
            cnt_d = '0;
            if (prd_q == dly_i) phase_d = PH_CLOSED;
            else                prd_d = prd_q + DLY_W'(1);
          end else begin
            cnt_d = cnt_q + PER_W'(1);
          end
        end
        PH_CLOSED: if (tick_i) begin
          if (cnt_q == cl_last) begin
            phase_d = PH_OPEN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + PER_W'(1);
          end
        end
        PH_OPEN: begin
          if (service_o || expire_o) begin
            phase_d = PH_CLOSED;
            cnt_d   = '0;
          end else if (tick_i) begin
            cnt_d = cnt_q + PER_W'(1);
          end
        end
        default: ;
      endcase
    end
    upd_en = tick_i || restart_o || service_o || ((phase_q != PH_OFF) && !active_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      prd_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      prd_q   <= prd_d;
    end
  end

  assign phase_o = phase_q;

  AST_OPEN_AFTER_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_OPEN) |-> $past(phase_q) == PH_CLOSED);  // R11
  AST_HOLD_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> phase_q == PH_OFF);  // R4
  AST_EXPIRY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> phase_q == PH_CLOSED);  // R6
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic [1:0] pdmd_i,
  input  logic       expire_i,
  input  logic       clear_i,
  output logic       irq_o,
  output logic       rst_req_o,
  output logic       pd_req_o,
  output logic [1:0] pd_mode_o
);
  localparam logic [1:0] STEP_LAST = 2'd2;

  logic [1:0] step_q, step_d;
  logic       step_en;
  logic       do_irq, do_rst, do_pd;
  logic       irq_q, rst_q, pd_q;
  logic [1:0] pdm_q;

  always_comb begin
    do_irq = 1'b0;
    do_rst = 1'b0;
    do_pd  = 1'b0;
    if (expire_i) begin
      unique case (mode_i)
        MODE_FULL: begin
          if (step_q == 2'd0)      do_irq = 1'b1;
          else if (step_q == 2'd1) do_rst = 1'b1;
          else                     do_pd  = 1'b1;
        end
        MODE_RST: begin
          if (step_q == 2'd0) do_rst = 1'b1;
          else                do_pd  = 1'b1;
        end
        MODE_PD: do_pd = 1'b1;
        default: ;
      endcase
    end
    step_en = clear_i || expire_i;
    if (clear_i)                 step_d = 2'd0;
    else if (step_q < STEP_LAST) step_d = step_q + 2'd1;
    else                         step_d = step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 2'd0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      irq_q <= do_irq;
      rst_q <= do_rst;
      pd_q  <= do_pd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdm_q <= 2'd0;
    end else if (do_pd) begin
      pdm_q <= pdmd_i;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
  assign pd_req_o  = pd_q;
  assign pd_mode_o = pdm_q;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, rst_q, pd_q}));  // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);  // R12
  AST_PD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> !pd_q);  // R12
  AST_PD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> pdm_q == $past(pdmd_i));  // R10
endmodule

// File: rtl/wdg_window_top.sv
module wdg_window_top
  import wdg_pkg::*;
#(
  parameter int               CODE_W = 8,
  parameter int               LEN_W  = 10,
  parameter int               DLY_W  = 3,
  parameter int               KEY_W  = 8,
  parameter logic [KEY_W-1:0] KEY    = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic              mode_wr_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              slp_en_i,
  input  logic              sleep_i,
  input  logic [CODE_W-1:0] close_code_i,
  input  logic [CODE_W-1:0] open_code_i,
  input  logic [1:0]        pdmd_i,
  input  logic              key_wr_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              stat_rd_i,
  output logic              open_o,
  output logic              early_o,
  output logic              expired_o,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic              pd_req_o,
  output logic [1:0]        pd_mode_o
);
  logic             rs1_q, rs2_q, rst_sync_n;
  logic [LEN_W-1:0] close_len, open_len;
  wdg_phase_e       phase;
  logic             active, restart, service, early_hit, expire;
  logic             early_q, exp_q, flag_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  wdg_len_dec #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_close_dec (
    .code_i(close_code_i), .len_o(close_len));
  wdg_len_dec #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_open_dec (
    .code_i(open_code_i), .len_o(open_len));

  wdg_phase_ctl #(.LEN_W(LEN_W), .DLY_W(DLY_W), .KEY_W(KEY_W), .KEY(KEY)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick_i), .mode_i(mode_i),
    .mode_wr_i(mode_wr_i), .dly_i(dly_i), .slp_en_i(slp_en_i), .sleep_i(sleep_i),
    .key_wr_i(key_wr_i), .key_i(key_i), .close_len_i(close_len),
    .open_len_i(open_len), .phase_o(phase), .active_o(active),
    .restart_o(restart), .service_o(service), .early_hit_o(early_hit),
    .expire_o(expire));

  wdg_escalate u_esc (
    .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_i), .pdmd_i(pdmd_i),
    .expire_i(expire), .clear_i(!active || restart || service),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .pd_req_o(pd_req_o),
    .pd_mode_o(pd_mode_o));

  assign flag_en = early_hit || expire || stat_rd_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      early_q <= 1'b0;
      exp_q   <= 1'b0;
    end else if (flag_en) begin
      early_q <= early_hit || (early_q && !stat_rd_i);
      exp_q   <= expire || (exp_q && !stat_rd_i);
    end
  end

  assign open_o    = (phase == PH_OPEN);
  assign early_o   = early_q;
  assign expired_o = exp_q;

  AST_EARLY_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    early_hit |=> early_o);  // R5
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire |=> expired_o);  // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == MODE_OFF) |=> (!open_o && !irq_o && !rst_req_o && !pd_req_o));  // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_rd_i && !early_hit) |=> !early_o);  // R7
endmodule

// File: tb/sim_wdg_window_top.sv
module sim_wdg_window_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, mode_wr_i, slp_en_i, sleep_i, key_wr_i, stat_rd_i;
  logic [1:0] mode_i, pdmd_i;
  logic [2:0] dly_i;
  logic [7:0] close_code_i, open_code_i, key_i;
  logic       open_o, early_o, expired_o, irq_o, rst_req_o, pd_req_o;
  logic [1:0] pd_mode_o;

  localparam logic [7:0] GOOD_KEY = 8'hA5;

  always #10 clk = ~clk;

  wdg_window_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i),
    .mode_wr_i(mode_wr_i), .dly_i(dly_i), .slp_en_i(slp_en_i), .sleep_i(sleep_i),
    .close_code_i(close_code_i), .open_code_i(open_code_i), .pdmd_i(pdmd_i),
    .key_wr_i(key_wr_i), .key_i(key_i), .stat_rd_i(stat_rd_i),
    .open_o(open_o), .early_o(early_o), .expired_o(expired_o), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .pd_req_o(pd_req_o), .pd_mode_o(pd_mode_o));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference state
  int m_ph, m_rem, m_step, m_hold;
  bit m_early, m_exp, m_irq, m_rst, m_pd;
  int m_pdm;

  function automatic int win_len(int c);
    if (c < 32)      return c + 1;
    else if (c < 64) return 34 + 2 * (c - 32);
    else             return 100 + 4 * (c - 64);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic predict();
    bit act, eset, xset;
    int cl, op;
    m_irq = 0; m_rst = 0; m_pd = 0;
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_step = 0; m_early = 0; m_exp = 0; m_pdm = 0; m_hold = 2;
      return;
    end
    if (m_hold > 0) begin m_hold--; return; end
    cl = win_len(close_code_i);
    op = win_len(open_code_i);
    act = (mode_i != 2'b00) && !(sleep_i && !slp_en_i);
    eset = 0; xset = 0;
    if (!act) begin
      m_ph = 0; m_step = 0;
    end else if (m_ph == 0 || mode_wr_i) begin
      m_ph = 1; m_rem = (dly_i + 1) * (cl + op); m_step = 0;
    end else if (m_ph == 1) begin
      if (tick_i) begin
        if (m_rem == 1) begin m_ph = 2; m_rem = cl; end else m_rem--;
      end
    end else if (m_ph == 2) begin
      if (key_wr_i) eset = 1;
      if (tick_i) begin
        if (m_rem == 1) begin m_ph = 3; m_rem = op; end else m_rem--;
      end
    end else begin
      if (key_wr_i && key_i == GOOD_KEY) begin
        m_ph = 2; m_rem = cl; m_step = 0;
      end else if (tick_i) begin
        if (m_rem == 1) begin
          xset = 1;
          case (mode_i)
            2'b01: if (m_step == 0) m_irq = 1; else if (m_step == 1) m_rst = 1; else m_pd = 1;
            2'b10: if (m_step == 0) m_rst = 1; else m_pd = 1;
            default: m_pd = 1;
          endcase
          if (m_pd) m_pdm = pdmd_i;
          m_ph = 2; m_rem = cl;
          if (m_step < 2) m_step++;
        end else m_rem--;
      end
    end
    m_early = eset || (m_early && !stat_rd_i);
    m_exp   = xset || (m_exp && !stat_rd_i);
  endtask

  task automatic check_all();
    chk(open_o == (m_ph == 3), "R11 open_o", open_o, m_ph == 3);
    chk(early_o == m_early, "R5 R7 early_o", early_o, m_early);
    chk(expired_o == m_exp, "R6 R7 expired_o", expired_o, m_exp);
    chk(irq_o == m_irq, "R9 R12 irq_o", irq_o, m_irq);
    chk(rst_req_o == m_rst, "R9 R12 rst_req_o", rst_req_o, m_rst);
    chk(pd_req_o == m_pd, "R9 R12 pd_req_o", pd_req_o, m_pd);
    chk(pd_mode_o == 2'(m_pdm), "R10 pd_mode_o", pd_mode_o, m_pdm);
  endtask

  task automatic cyc();
    predict();
    @(negedge clk);
    check_all();
    mode_wr_i = 0; key_wr_i = 0; stat_rd_i = 0;
  endtask

  task automatic disable_wd();
    mode_i = 2'b00; mode_wr_i = 1;
    repeat (3) cyc();
  endtask

  // returns 1=irq 2=rst 3=pd
  task automatic next_event(output int ev);
    ev = 0;
    for (int i = 0; i < 5000 && ev == 0; i++) begin
      cyc();
      if (irq_o) ev = 1; else if (rst_req_o) ev = 2; else if (pd_req_o) ev = 3;
    end
    cyc();
    chk(!irq_o && !rst_req_o && !pd_req_o, "R12 pulse width", 0, 0);
  endtask

  task automatic wait_open(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      cyc(); n++;
      if (open_o) break;
    end
  endtask

  task automatic decode_run(int cc, int oc, int d);
    int n, len, exp_first;
    disable_wd();
    close_code_i = 8'(cc); open_code_i = 8'(oc); dly_i = 3'(d);
    mode_i = 2'b01; mode_wr_i = 1;
    wait_open(n);
    exp_first = 1 + (d + 1) * (win_len(cc) + win_len(oc)) + win_len(cc);
    chk(n == exp_first, "R3 first open after delay", n, exp_first);
    len = 0;
    while (open_o && len < 2000) begin cyc(); len++; end
    chk(len == win_len(oc), "R1 open length", len, win_len(oc));
    len = 0;
    while (!open_o && len < 2000) begin cyc(); len++; end
    chk(len == win_len(cc), "R1 closed length", len, win_len(cc));
  endtask

  task automatic esc_run(int md, int e0, int e1, int e2, int e3);
    int ev;
    int exp_ev[4];
    exp_ev[0] = e0; exp_ev[1] = e1; exp_ev[2] = e2; exp_ev[3] = e3;
    disable_wd();
    close_code_i = 8'h01; open_code_i = 8'h02; dly_i = 3'd0; pdmd_i = 2'(md);
    mode_i = 2'(md); mode_wr_i = 1;
    for (int k = 0; k < 4; k++) begin
      next_event(ev);
      chk(ev == exp_ev[k], "R9 escalation order", ev, exp_ev[k]);
      if (ev == 3) chk(pd_mode_o == 2'(md), "R10 shutdown code", pd_mode_o, md);
    end
  endtask

  initial begin
    int n, ev, seg_len;
    void'($urandom(32'd4242));
    rst_n = 0; tick_i = 1; mode_i = 2'b01; mode_wr_i = 0; dly_i = 0;
    slp_en_i = 0; sleep_i = 0; close_code_i = 8'h02; open_code_i = 8'h03;
    pdmd_i = 2'b10; key_wr_i = 0; key_i = 0; stat_rd_i = 0;
    m_hold = 2; m_ph = 0; m_early = 0; m_exp = 0; m_pdm = 0; m_step = 0;
    repeat (3) cyc();
    chk(!open_o && !early_o && !expired_o && !irq_o && !rst_req_o && !pd_req_o
        && pd_mode_o == 0, "R11 reset state", open_o, 0);
    rst_n = 1;
    // start on reset release (R3)
    wait_open(n);
    chk(n == 2 + 1 + (win_len(2) + win_len(3)) + win_len(2), "R3 start after reset",
        n, 3 + (win_len(2) + win_len(3)) + win_len(2));

    // R1 / R3 decode boundaries
    decode_run(8'h00, 8'h1F, 0);
    decode_run(8'h1F, 8'h20, 1);
    decode_run(8'h20, 8'h3F, 7);
    decode_run(8'h40, 8'h41, 2);
    decode_run(8'h05, 8'hFF, 1);

    // R9 / R10 escalation per mode
    esc_run(1, 1, 2, 3, 3);
    esc_run(2, 2, 3, 3, 3);
    esc_run(3, 3, 3, 3, 3);

    // R8: valid key resets escalation; wrong key ignored
    disable_wd();
    close_code_i = 8'h02; open_code_i = 8'h04; dly_i = 0; mode_i = 2'b01; mode_wr_i = 1;
    next_event(ev);
    chk(ev == 1, "R8 first action irq", ev, 1);
    wait_open(n);
    key_wr_i = 1; key_i = GOOD_KEY; cyc();
    chk(!open_o, "R8 valid key closes window", open_o, 0);
    next_event(ev);
    chk(ev == 1, "R8 step reset after service", ev, 1);
    wait_open(n);
    key_wr_i = 1; key_i = 8'h5A; cyc();
    chk(open_o, "R8 wrong key ignored", open_o, 1);
    next_event(ev);
    chk(ev == 2, "R8 wrong key lets escalation continue", ev, 2);

    // R5 / R7 early write and read-clear
    while (open_o) cyc();
    key_wr_i = 1; key_i = GOOD_KEY; cyc();
    chk(early_o, "R5 early flag", early_o, 1);
    stat_rd_i = 1; cyc();
    chk(!early_o && !expired_o, "R7 read clears", early_o, 0);

    // R4 sleep hold-off and sleep run
    sleep_i = 1; slp_en_i = 0; cyc();
    n = 0;
    for (int i = 0; i < 60; i++) begin cyc(); n += open_o + irq_o + rst_req_o + pd_req_o; end
    chk(n == 0, "R4 held off in sleep", n, 0);
    slp_en_i = 1;
    n = 0;
    for (int i = 0; i < 60; i++) begin cyc(); n += open_o; end
    chk(n > 0, "R4 runs in sleep when allowed", n, 1);
    sleep_i = 0;

    // R2 disabled
    disable_wd();
    n = 0;
    for (int i = 0; i < 100; i++) begin cyc(); n += open_o + irq_o + rst_req_o + pd_req_o + early_o; end
    chk(n == 0, "R2 disabled idle", n, 0);

    // random segments
    for (int seg = 0; seg < 20; seg++) begin
      disable_wd();
      case ($urandom % 3)
        0: close_code_i = 8'($urandom % 8);
        1: close_code_i = 8'(32 + $urandom % 4);
        default: close_code_i = 8'(64 + $urandom % 2);
      endcase
      open_code_i = ($urandom % 2) ? 8'($urandom % 10) : 8'(32 + $urandom % 3);
      dly_i = 3'($urandom % 3);
      slp_en_i = 1'($urandom % 2);
      pdmd_i = 2'($urandom % 4);
      mode_i = 2'(1 + $urandom % 3); mode_wr_i = 1;
      seg_len = 1500;
      for (int i = 0; i < seg_len; i++) begin
        tick_i = ($urandom % 4) != 0;
        if ($urandom % 25 == 0) begin
          key_wr_i = 1;
          key_i = ($urandom % 2) ? GOOD_KEY : 8'($urandom % 256);
        end
        stat_rd_i = ($urandom % 6) == 0;
        if ($urandom % 300 == 0) sleep_i = !sleep_i;
        if ($urandom % 400 == 0) begin
          mode_i = 2'($urandom % 4); mode_wr_i = 1;
        end
        if ($urandom % 200 == 0) pdmd_i = 2'($urandom % 4);
        cyc();
      end
      sleep_i = 0; tick_i = 1;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog timeout R2 actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule